// File: doc/BRIEF.md
# DMX512 frame receiver

This block recovers lighting-control frames from a 250 kbaud serial line that has already been brought onto the chip's clock domain by a pin buffer. The line idles high. A frame opens with a long low period (the break) and a high gap (the mark after break). Characters follow, each one low start bit, eight data bits sent least significant bit first, and two high stop bits. The first character of a frame is a start code. Each later character is a data slot, and its number is its position in the frame.

The receiver passes the line through its own two-flop synchroniser. Three parts then work on it. A line monitor times low and high periods. A character sampler re-aligns on every falling start edge and reads each bit at mid-bit. A frame sequencer decides which slots are delivered. Data slots follow only the null start code (zero). Each slot is presented for one cycle with its number. Unsupported start codes, framing faults, a short mark after break and slots beyond the configured maximum each raise a one-cycle error pulse. Every break ends any open frame and reports whether that frame was damaged.

All timing limits are given in bit times of `CLKS_PER_BIT` clocks. The defaults are 400 clocks per bit, a 22-bit break (88 µs), a 2-bit mark after break (8 µs) and 512 data slots.

Top module: `dmx_frame_rx`

## Requirements
- R1: A frame opens only after the line has been low for at least `BRK_MIN_BITS` bit times and then high for at least `MAB_MIN_BITS` bit times. The opening is marked by a one-cycle `frm_start_o` pulse.
- R2: A low period shorter than the break limit is taken as an ordinary character. If its stop bits read low, it is a framing fault under R5. It neither opens nor closes a frame.
- R3: After a null start code (0x00), each character with both stop bits high gives one `slot_vld_o` pulse. `slot_data_o` carries the byte, with the first data bit on the line in bit 0. `slot_idx_o` counts 1, 2, 3 and so on from the first data slot of the frame.
- R4: A non-zero start code raises `err_code_o` for one cycle. No data slot of that frame is delivered.
- R5: A character whose first or second stop bit reads low raises `err_stop_o` once, when the line returns high. Neither that character nor any later character of the frame is delivered.
- R6: Data slots after number `MAX_SLOTS` are not delivered, and each one raises `err_ovf_o` for one cycle.
- R7: A break seen while a frame is open closes it with a one-cycle `frm_end_o` pulse. `frm_bad_o` is then 1 if the frame had an R4 or R5 fault, and 0 otherwise.
- R8: When a break is followed by a high period shorter than the mark-after-break limit, `err_mab_o` pulses at the next falling edge. No frame opens, and characters are ignored until the next break.
- R9: Any length of idle high between characters or between frames causes no error and no event.
- R10: Every start code received with good stop bits is placed on `sc_o` and marked by a one-cycle `sc_vld_o` pulse.
- R11: Under reset, every pulse output is 0 and `sc_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial line, idle high |
| slot_vld_o | output | 1 | One-cycle strobe for a delivered data slot |
| slot_idx_o | output | SLOT_W | Number of the slot, from 1 |
| slot_data_o | output | 8 | Slot byte |
| sc_vld_o | output | 1 | One-cycle strobe for a received start code |
| sc_o | output | 8 | Last received start code |
| frm_start_o | output | 1 | Frame opened (break and mark after break qualified) |
| frm_end_o | output | 1 | Open frame closed by a break |
| frm_bad_o | output | 1 | With `frm_end_o`: frame had a start-code or stop-bit fault |
| err_stop_o | output | 1 | Stop-bit fault in an open frame |
| err_code_o | output | 1 | Unsupported start code |
| err_ovf_o | output | 1 | Slot beyond the maximum |
| err_mab_o | output | 1 | Mark after break too short |

## Verification
The bench feeds null frames with slot bytes of all zeros, all ones and alternating bit patterns, so a bit-order or shift error shows up in the data. Gaps of zero, a few and many bit times between slots show whether alignment holds across idle mark. Separate frames put a low first stop bit and a low second stop bit mid-frame, and another uses a low period just short of a break. These three tell a framing fault apart from a frame boundary and confirm that the damaged slot and the slots after it are dropped. A non-zero start code, a frame longer than the slot limit and a mark after break one bit time long cover the remaining rejection paths. Each expected event is produced by a behavioural model in the bench, in the order in which the events must appear.

// File: rtl/dmx_rx_pkg.sv
package dmx_rx_pkg;

  typedef enum logic [2:0] {
    CH_IDLE,
    CH_START,
    CH_DATA,
    CH_STOP1,
    CH_STOP2,
    CH_HOLD
  } chr_state_t;

  typedef enum logic [2:0] {
    FR_HUNT,
    FR_MAB,
    FR_CODE,
    FR_DATA,
    FR_DROP
  } frm_state_t;

  localparam logic [7:0] NULL_CODE = 8'h00;

endpackage

// File: rtl/dmx_rx_sync.sv
module dmx_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dmx_rx_linemon.sv
module dmx_rx_linemon #(
  parameter int BRK_CLKS = 8800,
  parameter int MAB_CLKS = 800
) (
  input  logic clk,
  input  logic rst,
  input  logic rx,
  output logic brk_det,
  output logic brk_pend,
  output logic mab_ok,
  output logic mab_short
);

  localparam int LW = $clog2(BRK_CLKS + 1);
  localparam int HW = $clog2(MAB_CLKS + 1);
  localparam logic [LW-1:0] LOW_TOP = LW'(BRK_CLKS);
  localparam logic [LW-1:0] LOW_HIT = LW'(BRK_CLKS - 1);
  localparam logic [HW-1:0] HI_HIT  = HW'(MAB_CLKS - 1);

  logic [LW-1:0] low_cnt;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt   <= '0;
      hi_cnt    <= '0;
      brk_pend  <= 1'b0;
      brk_det   <= 1'b0;
      mab_ok    <= 1'b0;
      mab_short <= 1'b0;
    end else begin
      brk_det   <= 1'b0;
      mab_ok    <= 1'b0;
      mab_short <= 1'b0;
      if (!rx) begin
        hi_cnt <= '0;
        if (low_cnt != LOW_TOP) begin
          low_cnt <= low_cnt + 1'b1;
        end
        if (low_cnt == LOW_HIT) begin
          brk_det  <= 1'b1;
          brk_pend <= 1'b1;
        end else if (brk_pend && hi_cnt != '0) begin
          mab_short <= 1'b1;
          brk_pend  <= 1'b0;
        end
      end else begin
        low_cnt <= '0;
        if (brk_pend) begin
          if (hi_cnt == HI_HIT) begin
            mab_ok   <= 1'b1;
            brk_pend <= 1'b0;
            hi_cnt   <= '0;
          end else begin
            hi_cnt <= hi_cnt + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/dmx_rx_sampler.sv
module dmx_rx_sampler
  import dmx_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 400
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx,
  input  logic       brk_pend,
  output logic       chr_vld,
  output logic [7:0] chr_data,
  output logic       stop_err
);

  localparam int CW = $clog2(CLKS_PER_BIT);
  localparam logic [CW-1:0] FULL_M1 = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF_M1 = CW'(CLKS_PER_BIT / 2 - 1);

  chr_state_t  st;
  logic [CW-1:0] tick_cnt;
  logic [2:0]  bit_n;
  logic [7:0]  shift_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= CH_IDLE;
      tick_cnt <= '0;
      bit_n    <= '0;
      shift_q  <= '0;
      chr_vld  <= 1'b0;
      chr_data <= '0;
      stop_err <= 1'b0;
    end else begin
      chr_vld  <= 1'b0;
      stop_err <= 1'b0;
      case (st)
        CH_IDLE: begin
          if (!rx) begin
            st       <= CH_START;
            tick_cnt <= HALF_M1;
          end
        end
        CH_HOLD: begin
          if (rx) begin
            st <= CH_IDLE;
            if (!brk_pend) begin
              stop_err <= 1'b1;
            end
          end
        end
        default: begin
          if (tick_cnt != '0) begin
            tick_cnt <= tick_cnt - 1'b1;
          end else begin
            tick_cnt <= FULL_M1;
            case (st)
              CH_START: begin
                if (rx) begin
                  st <= CH_IDLE;
                end else begin
                  st    <= CH_DATA;
                  bit_n <= '0;
                end
              end
              CH_DATA: begin
                shift_q <= {rx, shift_q[7:1]};
                if (bit_n == 3'd7) begin
                  st <= CH_STOP1;
                end else begin
                  bit_n <= bit_n + 1'b1;
                end
              end
              CH_STOP1: begin
                st <= rx ? CH_STOP2 : CH_HOLD;
              end
              CH_STOP2: begin
                if (rx) begin
                  chr_vld  <= 1'b1;
                  chr_data <= shift_q;
                  st       <= CH_IDLE;
                end else begin
                  st <= CH_HOLD;
                end
              end
              default: st <= CH_IDLE;
            endcase
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/dmx_rx_framer.sv
module dmx_rx_framer
  import dmx_rx_pkg::*;
#(
  parameter int MAX_SLOTS = 512,
  parameter int SLOT_W    = $clog2(MAX_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chr_vld,
  input  logic [7:0]        chr_data,
  input  logic              stop_err,
  input  logic              brk_det,
  input  logic              mab_ok,
  input  logic              mab_short,
  output logic              slot_vld_o,
  output logic [SLOT_W-1:0] slot_idx_o,
  output logic [7:0]        slot_data_o,
  output logic              sc_vld_o,
  output logic [7:0]        sc_o,
  output logic              frm_start_o,
  output logic              frm_end_o,
  output logic              frm_bad_o,
  output logic              err_stop_o,
  output logic              err_code_o,
  output logic              err_ovf_o,
  output logic              err_mab_o
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(MAX_SLOTS);

  frm_state_t        st;
  logic [SLOT_W-1:0] slot_cnt;
  logic              bad_q;
  logic              open_st;

  assign open_st = (st == FR_CODE) || (st == FR_DATA) || (st == FR_DROP);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= FR_HUNT;
      slot_cnt    <= '0;
      bad_q       <= 1'b0;
      slot_vld_o  <= 1'b0;
      slot_idx_o  <= '0;
      slot_data_o <= '0;
      sc_vld_o    <= 1'b0;
      sc_o        <= NULL_CODE;
      frm_start_o <= 1'b0;
      frm_end_o   <= 1'b0;
      frm_bad_o   <= 1'b0;
      err_stop_o  <= 1'b0;
      err_code_o  <= 1'b0;
      err_ovf_o   <= 1'b0;
      err_mab_o   <= 1'b0;
    end else begin
      slot_vld_o  <= 1'b0;
      sc_vld_o    <= 1'b0;
      frm_start_o <= 1'b0;
      frm_end_o   <= 1'b0;
      err_stop_o  <= 1'b0;
      err_code_o  <= 1'b0;
      err_ovf_o   <= 1'b0;
      err_mab_o   <= 1'b0;
      if (brk_det) begin
        if (open_st) begin
          frm_end_o <= 1'b1;
          frm_bad_o <= bad_q;
        end
        st <= FR_MAB;
      end else if (mab_ok && st == FR_MAB) begin
        st          <= FR_CODE;
        frm_start_o <= 1'b1;
        bad_q       <= 1'b0;
        slot_cnt    <= '0;
      end else if (mab_short && st == FR_MAB) begin
        st        <= FR_HUNT;
        err_mab_o <= 1'b1;
      end else if (stop_err && (st == FR_CODE || st == FR_DATA)) begin
        err_stop_o <= 1'b1;
        bad_q      <= 1'b1;
        st         <= FR_DROP;
      end else if (chr_vld) begin
        case (st)
          FR_CODE: begin
            sc_o     <= chr_data;
            sc_vld_o <= 1'b1;
            if (chr_data == NULL_CODE) begin
              st <= FR_DATA;
            end else begin
              err_code_o <= 1'b1;
              bad_q      <= 1'b1;
              st         <= FR_DROP;
            end
          end
          FR_DATA: begin
            if (slot_cnt == LAST_SLOT) begin
              err_ovf_o <= 1'b1;
            end else begin
              slot_cnt    <= slot_cnt + 1'b1;
              slot_vld_o  <= 1'b1;
              slot_idx_o  <= slot_cnt + 1'b1;
              slot_data_o <= chr_data;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dmx_frame_rx.sv
module dmx_frame_rx #(
  parameter int CLKS_PER_BIT = 400,
  parameter int BRK_MIN_BITS = 22,
  parameter int MAB_MIN_BITS = 2,
  parameter int MAX_SLOTS    = 512,
  parameter int SYNC_STAGES  = 2,
  localparam int SLOT_W      = $clog2(MAX_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_i,
  output logic              slot_vld_o,
  output logic [SLOT_W-1:0] slot_idx_o,
  output logic [7:0]        slot_data_o,
  output logic              sc_vld_o,
  output logic [7:0]        sc_o,
  output logic              frm_start_o,
  output logic              frm_end_o,
  output logic              frm_bad_o,
  output logic              err_stop_o,
  output logic              err_code_o,
  output logic              err_ovf_o,
  output logic              err_mab_o
);

  localparam int BRK_CLKS = BRK_MIN_BITS * CLKS_PER_BIT;
  localparam int MAB_CLKS = MAB_MIN_BITS * CLKS_PER_BIT;

  logic       rx_s;
  logic       brk_det, brk_pend, mab_ok, mab_short;
  logic       chr_vld, stop_err;
  logic [7:0] chr_data;

  dmx_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (rx_i),
    .q_o (rx_s)
  );

  dmx_rx_linemon #(.BRK_CLKS(BRK_CLKS), .MAB_CLKS(MAB_CLKS)) u_linemon (
    .clk       (clk),
    .rst       (rst),
    .rx        (rx_s),
    .brk_det   (brk_det),
    .brk_pend  (brk_pend),
    .mab_ok    (mab_ok),
    .mab_short (mab_short)
  );

  dmx_rx_sampler #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_sampler (
    .clk      (clk),
    .rst      (rst),
    .rx       (rx_s),
    .brk_pend (brk_pend),
    .chr_vld  (chr_vld),
    .chr_data (chr_data),
    .stop_err (stop_err)
  );

  dmx_rx_framer #(.MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u_framer (
    .clk         (clk),
    .rst         (rst),
    .chr_vld     (chr_vld),
    .chr_data    (chr_data),
    .stop_err    (stop_err),
    .brk_det     (brk_det),
    .mab_ok      (mab_ok),
    .mab_short   (mab_short),
    .slot_vld_o  (slot_vld_o),
    .slot_idx_o  (slot_idx_o),
    .slot_data_o (slot_data_o),
    .sc_vld_o    (sc_vld_o),
    .sc_o        (sc_o),
    .frm_start_o (frm_start_o),
    .frm_end_o   (frm_end_o),
    .frm_bad_o   (frm_bad_o),
    .err_stop_o  (err_stop_o),
    .err_code_o  (err_code_o),
    .err_ovf_o   (err_ovf_o),
    .err_mab_o   (err_mab_o)
  );

endmodule

// File: rtl/dmx_frame_rx_chk.sv
module dmx_frame_rx_chk #(
  parameter int CLKS_PER_BIT = 400,
  parameter int BRK_MIN_BITS = 22,
  parameter int MAX_SLOTS    = 512,
  parameter int SLOT_W       = $clog2(MAX_SLOTS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_i,
  input logic              slot_vld_o,
  input logic [SLOT_W-1:0] slot_idx_o,
  input logic              sc_vld_o,
  input logic [7:0]        sc_o,
  input logic              frm_start_o,
  input logic              frm_end_o,
  input logic              err_code_o,
  input logic              err_ovf_o
);

  localparam int BRK_CLKS = BRK_MIN_BITS * CLKS_PER_BIT;
  localparam int LW = $clog2(BRK_CLKS + 1);
  localparam logic [LW-1:0] LOW_TOP = LW'(BRK_CLKS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(MAX_SLOTS);

  logic [LW-1:0]     low_run, last_low;
  logic              rx_prev, open_q;
  logic [SLOT_W-1:0] last_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run  <= '0;
      last_low <= '0;
      rx_prev  <= 1'b1;
      open_q   <= 1'b0;
      last_idx <= '0;
    end else begin
      rx_prev <= rx_i;
      if (!rx_i) begin
        if (low_run != LOW_TOP) low_run <= low_run + 1'b1;
      end else begin
        low_run <= '0;
        if (!rx_prev) last_low <= low_run;
      end
      if (frm_start_o) begin
        open_q   <= 1'b1;
        last_idx <= '0;
      end else if (frm_end_o) begin
        open_q <= 1'b0;
      end
      if (slot_vld_o) last_idx <= slot_idx_o;
    end
  end

  AST_BREAK_BEFORE_START: assert property (@(posedge clk) disable iff (rst)
    frm_start_o |-> (last_low == LOW_TOP)); // R1
  AST_SLOT_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    slot_vld_o |-> open_q); // R3
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    slot_vld_o |-> (slot_idx_o == last_idx + 1'b1)); // R3
  AST_SLOT_NULL_CODE: assert property (@(posedge clk) disable iff (rst)
    slot_vld_o |-> (sc_o == 8'h00)); // R4
  AST_CODE_ERR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    err_code_o |-> (sc_vld_o && sc_o != 8'h00)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    err_ovf_o |-> (!slot_vld_o && last_idx == LAST_SLOT)); // R6
  AST_END_NEEDS_OPEN: assert property (@(posedge clk) disable iff (rst)
    frm_end_o |-> open_q); // R7

endmodule

bind dmx_frame_rx dmx_frame_rx_chk #(
  .CLKS_PER_BIT (CLKS_PER_BIT),
  .BRK_MIN_BITS (BRK_MIN_BITS),
  .MAX_SLOTS    (MAX_SLOTS),
  .SLOT_W       (SLOT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_i        (rx_i),
  .slot_vld_o  (slot_vld_o),
  .slot_idx_o  (slot_idx_o),
  .sc_vld_o    (sc_vld_o),
  .sc_o        (sc_o),
  .frm_start_o (frm_start_o),
  .frm_end_o   (frm_end_o),
  .err_code_o  (err_code_o),
  .err_ovf_o   (err_ovf_o)
);

// File: tb/dmx_frame_rx_bench.sv
module dmx_frame_rx_bench;

  localparam int CPB  = 16;
  localparam int MAXS = 8;
  localparam int SW   = $clog2(MAXS + 1);
  localparam int BRKB = 22;
  localparam int MABB = 2;

  localparam int K_END = 0, K_START = 1, K_SC = 2, K_ECODE = 3;
  localparam int K_SLOT = 4, K_OVF = 5, K_ESTOP = 6, K_EMAB = 7;

  localparam int M_HUNT = 0, M_CODE = 1, M_DATA = 2, M_DROP = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx  = 1'b1;
  logic          slot_vld_o, sc_vld_o, frm_start_o, frm_end_o, frm_bad_o;
  logic          err_stop_o, err_code_o, err_ovf_o, err_mab_o;
  logic [SW-1:0] slot_idx_o;
  logic [7:0]    slot_data_o, sc_o;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;
  bit live  = 1'b0;
  string ctx = "R11 reset";

  int qk[$];
  int qa[$];
  int qb[$];

  int md = M_HUNT;
  bit open_f = 1'b0;
  bit bad_f = 1'b0;
  int cnt = 0;

  always #5 clk = ~clk;

  dmx_frame_rx #(
    .CLKS_PER_BIT (CPB),
    .MAX_SLOTS    (MAXS)
  ) u_dmx_frame_rx (
    .clk         (clk),
    .rst         (rst),
    .rx_i        (rx),
    .slot_vld_o  (slot_vld_o),
    .slot_idx_o  (slot_idx_o),
    .slot_data_o (slot_data_o),
    .sc_vld_o    (sc_vld_o),
    .sc_o        (sc_o),
    .frm_start_o (frm_start_o),
    .frm_end_o   (frm_end_o),
    .frm_bad_o   (frm_bad_o),
    .err_stop_o  (err_stop_o),
    .err_code_o  (err_code_o),
    .err_ovf_o   (err_ovf_o),
    .err_mab_o   (err_mab_o)
  );

  function automatic string tag(int k);
    case (k)
      K_END:   return "R7";
      K_START: return "R1";
      K_SC:    return "R10";
      K_ECODE: return "R4";
      K_SLOT:  return "R3";
      K_OVF:   return "R6";
      K_ESTOP: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic expect_ev(int k, int a, int b);
    qk.push_back(k);
    qa.push_back(a);
    qb.push_back(b);
  endtask

  task automatic got(int k, int a, int b);
    total++;
    if (qk.size() == 0) begin
      fails++;
      $display("FAIL %s [%s]: got kind=%0d a=%0d b=%0d expected no event",
               tag(k), ctx, k, a, b);
    end else begin
      int ek = qk.pop_front();
      int ea = qa.pop_front();
      int eb = qb.pop_front();
      if (ek != k || ea != a || eb != b) begin
        fails++;
        $display("FAIL %s [%s]: got kind=%0d a=%0d b=%0d expected kind=%0d a=%0d b=%0d",
                 tag(ek), ctx, k, a, b, ek, ea, eb);
      end
    end
  endtask

  // Event stream comparison on every clock, in a fixed order per cycle
  always @(negedge clk) begin
    if (live && !rst) begin
      if (frm_end_o)   got(K_END, 0, int'(frm_bad_o));
      if (frm_start_o) got(K_START, 0, 0);
      if (sc_vld_o)    got(K_SC, int'(sc_o), 0);
      if (err_code_o)  got(K_ECODE, 0, 0);
      if (slot_vld_o)  got(K_SLOT, int'(slot_idx_o), int'(slot_data_o));
      if (err_ovf_o)   got(K_OVF, 0, 0);
      if (err_stop_o)  got(K_ESTOP, 0, 0);
      if (err_mab_o)   got(K_EMAB, 0, 0);
    end
  end

  task automatic hold(logic v, int bits);
    rx = v;
    repeat (bits * CPB) @(negedge clk);
  endtask

  // Reference model: break / short low
  task automatic do_break(int low_bits, int mab_bits);
    if (low_bits >= BRKB) begin
      if (open_f) expect_ev(K_END, 0, int'(bad_f));
      open_f = 1'b0;
      if (mab_bits >= MABB) begin
        expect_ev(K_START, 0, 0);
        open_f = 1'b1;
        bad_f  = 1'b0;
        cnt    = 0;
        md     = M_CODE;
      end else begin
        expect_ev(K_EMAB, 0, 0);
        md = M_HUNT;
      end
    end else if (md == M_CODE || md == M_DATA) begin
      expect_ev(K_ESTOP, 0, 0);
      md    = M_DROP;
      bad_f = 1'b1;
    end
    hold(1'b0, low_bits);
    hold(1'b1, mab_bits);
  endtask

  // Reference model: one character
  task automatic send_byte(logic [7:0] b, logic s1, logic s2, int gap);
    bit ok = s1 && s2;
    if (md == M_CODE) begin
      if (!ok) begin
        expect_ev(K_ESTOP, 0, 0);
        md = M_DROP; bad_f = 1'b1;
      end else begin
        expect_ev(K_SC, int'(b), 0);
        if (b != 8'h00) begin
          expect_ev(K_ECODE, 0, 0);
          md = M_DROP; bad_f = 1'b1;
        end else begin
          md = M_DATA;
        end
      end
    end else if (md == M_DATA) begin
      if (!ok) begin
        expect_ev(K_ESTOP, 0, 0);
        md = M_DROP; bad_f = 1'b1;
      end else if (cnt == MAXS) begin
        expect_ev(K_OVF, 0, 0);
      end else begin
        cnt++;
        expect_ev(K_SLOT, cnt, int'(b));
      end
    end
    hold(1'b0, 1);
    for (int i = 0; i < 8; i++) hold(b[i], 1);
    hold(s1, 1);
    hold(s2, 1);
    hold(1'b1, gap);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog [%s]: got hung run expected completion", ctx);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (6) @(negedge clk);
    // R11: reset state
    total++;
    if (slot_vld_o || sc_vld_o || frm_start_o || frm_end_o || err_stop_o ||
        err_code_o || err_ovf_o || err_mab_o || sc_o != 8'h00) begin
      fails++;
      $display("FAIL R11 [%s]: got pulses/sc=%0d expected all zero", ctx, sc_o);
    end
    rst = 1'b0;
    live = 1'b1;

    ctx = "R9 idle before first frame";
    hold(1'b1, 40);

    ctx = "R1 R3 null frame, varied gaps";
    do_break(24, 3);
    send_byte(8'h00, 1, 1, 0);
    send_byte(8'h00, 1, 1, 0);
    send_byte(8'hFF, 1, 1, 5);
    send_byte(8'hA5, 1, 1, 0);
    send_byte(8'h5A, 1, 1, 30);

    ctx = "R9 long idle between frames";
    hold(1'b1, 200);

    ctx = "R4 R7 unsupported start code";
    do_break(25, 3);
    send_byte(8'hCC, 1, 1, 1);
    send_byte(8'h11, 1, 1, 1);
    send_byte(8'h22, 1, 1, 1);

    ctx = "R5 first stop bit low";
    do_break(24, 4);
    send_byte(8'h00, 1, 1, 0);
    send_byte(8'h37, 1, 1, 0);
    send_byte(8'h81, 0, 1, 2);
    send_byte(8'h44, 1, 1, 2);

    ctx = "R5 second stop bit low";
    do_break(24, 3);
    send_byte(8'h00, 1, 1, 0);
    send_byte(8'h12, 1, 0, 2);
    send_byte(8'h34, 1, 1, 2);

    ctx = "R2 low just short of a break";
    do_break(24, 3);
    send_byte(8'h00, 1, 1, 0);
    send_byte(8'h99, 1, 1, 3);
    do_break(20, 2);
    send_byte(8'h55, 1, 1, 3);

    ctx = "R6 slot limit";
    do_break(24, 3);
    send_byte(8'h00, 1, 1, 0);
    for (int i = 1; i <= MAXS + 2; i++) send_byte(8'(i * 8'h11), 1, 1, 0);
    hold(1'b1, 4);

    ctx = "R8 short mark after break";
    do_break(24, 1);
    send_byte(8'h00, 1, 1, 0);
    send_byte(8'h77, 1, 1, 4);
    do_break(23, 3);
    send_byte(8'h00, 1, 1, 0);
    send_byte(8'h42, 1, 1, 2);

    ctx = "R7 break closes clean frame";
    do_break(30, 3);
    hold(1'b1, 20);

    ctx = "end of run";
    total++;
    if (qk.size() != 0) begin
      fails++;
      $display("FAIL %s [%s]: got %0d events missing expected 0 (next kind=%0d)",
               tag(qk[0]), ctx, qk.size(), qk[0]);
    end
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule